// File: doc/BRIEF.md
# Buffered SPI Master with In-Place Receive

This block is an SPI master that a host drives through a small byte-wide memory map. The host fills a 1024-byte buffer with the bytes to send. It then writes a control word that carries a byte count and a start bit. The shift engine clocks the bytes out in SPI mode 0, most significant bit first. Each byte received from the slave overwrites the buffer slot that its outgoing byte came from, so after completion the host reads the reply from the same addresses it wrote.

Chip select stays asserted at the end of a command unless that command carries the last-fragment flag. A message longer than the buffer can therefore be sent as several fragments under one chip-select window. A separate release write drops chip select without a transfer, which puts the bus into a known state before a new message starts. When a command ends, a pending flag is set. The interrupt output follows that flag when it is enabled.

Top module: `spi_buf_master`

## Requirements
- R1: Host map (byte addresses, 8-bit data): buffer at 0..1023, control low/high bytes at 1024/1025, divider low/high bytes at 1026/1027. host_rdata shows the addressed byte one clock after the address is presented. After reset: control reads 0, the divider reads 2, spi_cs_n=1, spi_sck=0 and irq=0.
- R2: Control word fields: bits 9:0 hold the length, bit 15 is start, bit 14 is last-fragment, bit 13 is interrupt enable and bit 12 is the pending flag. A transfer begins when byte 1025 is written with bit 7 (word bit 15) set.
- R3: Transfers run in mode 0. spi_sck idles low. spi_mosi changes only while spi_sck is low. spi_miso is sampled on the rising edge. Bytes are sent MSB first, in buffer order starting at address 0.
- R4: Each received byte replaces the buffer byte sent at the same position.
- R5: A length of 0 together with start transfers all 1024 bytes.
- R6: Each SCK half period lasts D system clocks, where D is the divider value; a value of 0 acts as 1. One bit therefore takes 2*D clocks.
- R7: spi_cs_n is low for the whole transfer. It stays low after a command without last-fragment and goes high at the end of a command with it.
- R8: While idle, writing byte 1025 with bit 6 set and bit 7 clear drives spi_cs_n high. No transfer takes place.
- R9: The pending flag (bit 12) is set when a transfer completes. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R10: irq is high exactly when both the pending flag and interrupt enable are set.
- R11: While a transfer runs, the start bit reads 1, buffer writes are ignored and new start writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Write strobe for host_addr/host_wdata |
| host_addr | input | 11 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data for the previous cycle's address |
| irq | output | 1 | Interrupt request |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench attaches a mode-0 slave model that answers from a running byte sequence. A scoreboard queue holds the bytes the host loaded, and each byte seen on MOSI is compared against it. Short single-byte-count transfers at several divider values, including 0, separate a wrong bit period from a wrong bit order. A two-fragment message shows that chip select is held and that the slave's reply stream stays in step across commands. The full 1024-byte transfer with a zero length field exposes any off-by-one in the byte counter or the wrap of the buffer index. A slow transfer gives the bench time to try buffer and start writes while busy, and a buffer slot outside the active range shows whether such writes leaked through.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;

    // Control word bit positions (word view of bytes 1024/1025)
    localparam int CTL_START = 15;
    localparam int CTL_LAST  = 14;
    localparam int CTL_IE    = 13;
    localparam int CTL_PEND  = 12;

    // Register byte offsets above the buffer
    localparam logic [1:0] OFF_CTRL_LO = 2'd0;
    localparam logic [1:0] OFF_CTRL_HI = 2'd1;
    localparam logic [1:0] OFF_DIV_LO  = 2'd2;
    localparam logic [1:0] OFF_DIV_HI  = 2'd3;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_LOW  = 2'd1,
        ENG_HIGH = 2'd2
    } eng_state_e;

endpackage

// File: rtl/spi_buf_ram.sv
module spi_buf_ram #(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    input  logic             eng_we,
    input  logic [IDX_W-1:0] eng_widx,
    input  logic [7:0]       eng_wdata,
    input  logic [IDX_W-1:0] eng_ridx,
    output logic [7:0]       eng_rdata
);
    // Byte store; the engine owns it while busy, the host otherwise.
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (eng_we) begin
            mem_q[eng_widx] <= eng_wdata;
        end else if (host_we) begin
            mem_q[host_idx] <= host_wdata;
        end
    end

    assign host_rdata = mem_q[host_idx];
    assign eng_rdata  = mem_q[eng_ridx];

    // R11
    no_port_clash_chk: assert property (@(posedge clk) !(host_we && eng_we));

endmodule

// File: rtl/spi_buf_regs.sv
module spi_buf_regs #(
    parameter int IDX_W     = 10,
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 2,
    localparam int LEN_HI_W = IDX_W - 8,
    localparam int PAD_W    = 12 - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_lo_we,
    input  logic             ctrl_hi_we,
    input  logic             div_lo_we,
    input  logic             div_hi_we,
    input  logic [7:0]       wdata,
    input  logic             busy_i,
    input  logic             done_i,
    output logic             start_o,
    output logic             release_o,
    output logic [IDX_W-1:0] len_o,
    output logic             last_o,
    output logic [DIV_W-1:0] div_o,
    output logic [15:0]      ctrl_o,
    output logic             irq_o
);
    import spi_buf_pkg::*;

    typedef struct packed {
        logic [IDX_W-1:0] len;
        logic             last;
        logic             ie;
        logic             pend;
        logic [DIV_W-1:0] div;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  start_d, release_d;

    always_comb begin
        regs_d    = regs_q;
        start_d   = 1'b0;
        release_d = 1'b0;
        if (ctrl_lo_we && !busy_i) begin
            regs_d.len[7:0] = wdata;
        end
        if (ctrl_hi_we) begin
            regs_d.ie = wdata[CTL_IE - 8];
            if (wdata[CTL_PEND - 8]) begin
                regs_d.pend = 1'b0;
            end
            if (!busy_i) begin
                regs_d.len[IDX_W-1:8] = wdata[LEN_HI_W-1:0];
                regs_d.last           = wdata[CTL_LAST - 8];
                if (wdata[CTL_START - 8]) begin
                    start_d = 1'b1;
                end else if (wdata[CTL_LAST - 8]) begin
                    release_d = 1'b1;
                end
            end
        end
        if (div_lo_we) begin
            regs_d.div[7:0] = wdata;
        end
        if (div_hi_we) begin
            regs_d.div[DIV_W-1:8] = wdata[DIV_W-9:0];
        end
        if (done_i) begin
            regs_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q      <= '0;
            regs_q.div  <= DIV_W'(DIV_RESET);
        end else begin
            regs_q <= regs_d;
        end
    end

    // The engine latches length and flag on the start cycle itself.
    assign start_o   = start_d;
    assign release_o = release_d;
    assign len_o     = regs_d.len;
    assign last_o    = regs_d.last;
    assign div_o     = regs_q.div;
    assign irq_o     = regs_q.pend & regs_q.ie;
    assign ctrl_o    = {busy_i, regs_q.last, regs_q.ie, regs_q.pend,
                        {PAD_W{1'b0}}, regs_q.len};

    // R9
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> regs_q.pend);

    // R9
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hi_we && wdata[CTL_PEND - 8] && !done_i) |=> !regs_q.pend);

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && regs_q.ie && !ctrl_hi_we) |=> irq_o);

endmodule

// File: rtl/spi_buf_shift.sv
module spi_buf_shift #(
    parameter int IDX_W = 10,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             release_i,
    input  logic [IDX_W-1:0] len_i,
    input  logic             last_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [7:0]       rd_byte_i,
    input  logic             miso_i,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [7:0]       wr_byte_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             sck_o,
    output logic             mosi_o,
    output logic             cs_n_o
);
    import spi_buf_pkg::*;

    typedef struct packed {
        eng_state_e       state;
        logic [DIV_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last_idx;
        logic [2:0]       bit_idx;
        logic [7:0]       shreg;
        logic             samp;
        logic             sck;
        logic             cs_act;
        logic             rel_end;
    } eng_t;

    eng_t             eng_d, eng_q;
    logic [DIV_W-1:0] half_m1;
    logic             half_end;
    logic             done_d, we_d;

    assign half_m1  = (div_i == '0) ? '0 : div_i - 1'b1;
    assign half_end = (eng_q.cnt == half_m1);

    always_comb begin
        eng_d  = eng_q;
        done_d = 1'b0;
        we_d   = 1'b0;
        unique case (eng_q.state)
            ENG_IDLE: begin
                if (start_i) begin
                    eng_d.state    = ENG_LOW;
                    eng_d.cnt      = '0;
                    eng_d.idx      = '0;
                    eng_d.last_idx = len_i - 1'b1;
                    eng_d.bit_idx  = 3'd7;
                    eng_d.shreg    = rd_byte_i;
                    eng_d.cs_act   = 1'b1;
                    eng_d.rel_end  = last_i;
                end else if (release_i) begin
                    eng_d.cs_act = 1'b0;
                end
            end
            ENG_LOW: begin
                if (half_end) begin
                    eng_d.cnt   = '0;
                    eng_d.sck   = 1'b1;
                    eng_d.samp  = miso_i;
                    eng_d.state = ENG_HIGH;
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
            ENG_HIGH: begin
                if (half_end) begin
                    eng_d.cnt   = '0;
                    eng_d.sck   = 1'b0;
                    eng_d.state = ENG_LOW;
                    if (eng_q.bit_idx == 3'd0) begin
                        we_d = 1'b1;
                        if (eng_q.idx == eng_q.last_idx) begin
                            eng_d.state = ENG_IDLE;
                            eng_d.shreg = '0;
                            done_d      = 1'b1;
                            if (eng_q.rel_end) begin
                                eng_d.cs_act = 1'b0;
                            end
                        end else begin
                            eng_d.idx     = eng_q.idx + 1'b1;
                            eng_d.shreg   = rd_byte_i;
                            eng_d.bit_idx = 3'd7;
                        end
                    end else begin
                        eng_d.shreg   = {eng_q.shreg[6:0], eng_q.samp};
                        eng_d.bit_idx = eng_q.bit_idx - 1'b1;
                    end
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
            default: eng_d.state = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    // Next byte is prefetched from the slot after the one being shifted.
    assign busy_o    = (eng_q.state != ENG_IDLE);
    assign rd_idx_o  = busy_o ? eng_q.idx + 1'b1 : '0;
    assign wr_en_o   = we_d;
    assign wr_idx_o  = eng_q.idx;
    assign wr_byte_o = {eng_q.shreg[6:0], eng_q.samp};
    assign done_o    = done_d;
    assign sck_o     = eng_q.sck;
    assign mosi_o    = eng_q.shreg[7];
    assign cs_n_o    = !eng_q.cs_act;

    // R7
    cs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !cs_n_o);

    // R7
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && eng_q.rel_end) |=> cs_n_o);

    // R3
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sck_o);

    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(mosi_o));

    // R11
    start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(eng_q.last_idx));

endmodule

// File: rtl/spi_buf_master.sv
module spi_buf_master #(
    parameter int BUF_BYTES = 1024,
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 2,
    localparam int IDX_W    = $clog2(BUF_BYTES),
    localparam int ADDR_W   = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              irq,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    import spi_buf_pkg::*;

    logic             buf_sel, reg_sel;
    logic [1:0]       reg_off;
    logic             ctrl_lo_we, ctrl_hi_we, div_lo_we, div_hi_we;
    logic             busy, done, start, release_cs, last_flag;
    logic [IDX_W-1:0] len;
    logic [DIV_W-1:0] div;
    logic [15:0]      ctrl_word;
    logic [7:0]       ram_host_rdata, ram_eng_rdata;
    logic [IDX_W-1:0] eng_ridx, eng_widx;
    logic             eng_we;
    logic [7:0]       eng_wbyte;
    logic [7:0]       rdata_d, rdata_q;

    assign buf_sel = !host_addr[ADDR_W-1];
    assign reg_sel = host_addr[ADDR_W-1] && (host_addr[ADDR_W-2:2] == '0);
    assign reg_off = host_addr[1:0];

    assign ctrl_lo_we = host_wr && reg_sel && (reg_off == OFF_CTRL_LO);
    assign ctrl_hi_we = host_wr && reg_sel && (reg_off == OFF_CTRL_HI);
    assign div_lo_we  = host_wr && reg_sel && (reg_off == OFF_DIV_LO);
    assign div_hi_we  = host_wr && reg_sel && (reg_off == OFF_DIV_HI);

    spi_buf_regs #(
        .IDX_W(IDX_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_lo_we (ctrl_lo_we),
        .ctrl_hi_we (ctrl_hi_we),
        .div_lo_we  (div_lo_we),
        .div_hi_we  (div_hi_we),
        .wdata      (host_wdata),
        .busy_i     (busy),
        .done_i     (done),
        .start_o    (start),
        .release_o  (release_cs),
        .len_o      (len),
        .last_o     (last_flag),
        .div_o      (div),
        .ctrl_o     (ctrl_word),
        .irq_o      (irq)
    );

    spi_buf_ram #(.DEPTH(BUF_BYTES)) u_ram (
        .clk        (clk),
        .host_we    (host_wr && buf_sel && !busy),
        .host_idx   (host_addr[IDX_W-1:0]),
        .host_wdata (host_wdata),
        .host_rdata (ram_host_rdata),
        .eng_we     (eng_we),
        .eng_widx   (eng_widx),
        .eng_wdata  (eng_wbyte),
        .eng_ridx   (eng_ridx),
        .eng_rdata  (ram_eng_rdata)
    );

    spi_buf_shift #(.IDX_W(IDX_W), .DIV_W(DIV_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .release_i (release_cs),
        .len_i     (len),
        .last_i    (last_flag),
        .div_i     (div),
        .rd_byte_i (ram_eng_rdata),
        .miso_i    (spi_miso),
        .rd_idx_o  (eng_ridx),
        .wr_en_o   (eng_we),
        .wr_idx_o  (eng_widx),
        .wr_byte_o (eng_wbyte),
        .busy_o    (busy),
        .done_o    (done),
        .sck_o     (spi_sck),
        .mosi_o    (spi_mosi),
        .cs_n_o    (spi_cs_n)
    );

    always_comb begin
        rdata_d = '0;
        if (buf_sel) begin
            rdata_d = ram_host_rdata;
        end else if (reg_sel) begin
            unique case (reg_off)
                OFF_CTRL_LO: rdata_d = ctrl_word[7:0];
                OFF_CTRL_HI: rdata_d = ctrl_word[15:8];
                OFF_DIV_LO:  rdata_d = div[7:0];
                default:     rdata_d = div[DIV_W-1:8];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign host_rdata = rdata_q;

    // R11
    start_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_sel && (reg_off == OFF_CTRL_HI)) |=> host_rdata[7]);

endmodule

// File: tb/sim_spi_buf_master.sv
module sim_spi_buf_master;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [10:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        irq, spi_sck, spi_mosi, spi_cs_n;
    logic        spi_miso;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_buf_master u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp_v);
        end
    endtask

    function automatic logic [7:0] slv_byte(input int k);
        return 8'((k * 37 + 8'h5A) & 8'hFF);
    endfunction

    function automatic logic [7:0] tx_byte(input int seed, input int i);
        return 8'((seed * 13 + i * 5 + 1) & 8'hFF);
    endfunction

    // Slave model (mode 0) and scoreboard monitor
    logic [7:0] exp_mosi[$];
    logic [7:0] sl_out = '0;
    logic [7:0] sl_in  = '0;
    int sl_bits = 0;
    int sl_idx  = 0;
    int t_r0 = 0, t_r1 = 0;
    assign spi_miso = sl_out[7];

    always @(negedge spi_cs_n) begin
        sl_out  = slv_byte(sl_idx);
        sl_bits = 0;
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            sl_in = {sl_in[6:0], spi_mosi};
            sl_bits++;
            if (sl_bits == 1) t_r0 = cyc;
            if (sl_bits == 2) t_r1 = cyc;
            if (sl_bits == 8) begin
                sl_idx++;
                if (exp_mosi.size() == 0) begin
                    chk(1'b0, "R3 unexpected MOSI byte", sl_in, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_mosi.pop_front();
                    chk(sl_in == e, "R3 MOSI byte", sl_in, e);
                end
            end
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n) begin
            if (sl_bits == 8) begin
                sl_bits = 0;
                sl_out  = slv_byte(sl_idx);
            end else begin
                sl_out = {sl_out[6:0], 1'b0};
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        host_addr  = 11'(a);
        host_wdata = 8'(d);
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        host_wr   = 1'b0;
        host_addr = 11'(a);
        @(negedge clk);
        d = host_rdata;
    endtask

    logic [7:0] exp_rx [1024];
    int rx_k = 0;

    // Driver: load buffer, queue expected MOSI bytes and replies
    task automatic prep(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            wr(i, tx_byte(seed, i));
            exp_mosi.push_back(tx_byte(seed, i));
            exp_rx[i] = slv_byte(rx_k + i);
        end
        rx_k += n;
    endtask

    // Start with pend cleared (bit4) in the same write
    task automatic launch(input int n, input bit last, input bit ie);
        int lf;
        lf = n & 10'h3FF;
        wr(1024, lf & 8'hFF);
        wr(1025, {1'b1, last, ie, 1'b1, 2'b00, 2'(lf >> 8)});
    endtask

    task automatic wait_done;
        logic [7:0] v;
        int guard;
        guard = 0;
        v = '0;
        while (!v[4] && guard < 40000) begin
            rd(1025, v);
            guard++;
        end
        chk(v[4] == 1'b1, "R9 pending set on completion", v, 8'h10);
    endtask

    task automatic check_rx(input int n, input string tag);
        logic [7:0] v;
        int bad, first_a, first_e;
        bad = 0; first_a = 0; first_e = 0;
        for (int i = 0; i < n; i++) begin
            rd(i, v);
            if (v != exp_rx[i]) begin
                if (bad == 0) begin first_a = v; first_e = exp_rx[i]; end
                bad++;
            end
        end
        chk(bad == 0, tag, first_a, first_e);
        chk(exp_mosi.size() == 0, "R3 all queued bytes shifted", exp_mosi.size(), 0);
    endtask

    task automatic run_cmd(input int n, input bit last, input bit ie, input int seed);
        prep(n, seed);
        launch(n, last, ie);
        wait_done();
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and map
        chk(spi_cs_n == 1'b1, "R1 cs_n after reset", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R1 sck after reset", spi_sck, 0);
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);
        rd(1024, v); chk(v == 8'h00, "R1 ctrl low reset", v, 0);
        rd(1025, v); chk(v == 8'h00, "R1 ctrl high reset", v, 0);
        rd(1026, v); chk(v == 8'h02, "R1 divider low reset", v, 2);
        rd(1027, v); chk(v == 8'h00, "R1 divider high reset", v, 0);

        // R2 R4 R6 R7 R10: 4 bytes, last, irq enabled, divider 2
        run_cmd(4, 1'b1, 1'b1, 1);
        check_rx(4, "R4 in-place receive, 4 bytes");
        chk(t_r1 - t_r0 == 4, "R6 bit period at divider 2", t_r1 - t_r0, 4);
        chk(spi_cs_n == 1'b1, "R7 cs released after last", spi_cs_n, 1);
        chk(irq == 1'b1, "R10 irq with enable and pending", irq, 1);
        rd(1025, v); chk(v == 8'h70, "R2 ctrl high after done", v, 8'h70);
        rd(1024, v); chk(v == 8'h04, "R2 length field readback", v, 8'h04);

        // R9 write-one-to-clear
        wr(1025, 8'h20);
        chk(irq == 1'b1, "R9 writing 0 to pending keeps it", irq, 1);
        wr(1025, 8'h30);
        chk(irq == 1'b0, "R9 writing 1 clears pending", irq, 0);
        rd(1025, v); chk(v == 8'h20, "R9 ctrl after clear", v, 8'h20);

        // R6 R10: divider 3, interrupt disabled
        wr(1026, 3);
        run_cmd(3, 1'b1, 1'b0, 2);
        check_rx(3, "R4 in-place receive, divider 3");
        chk(t_r1 - t_r0 == 6, "R6 bit period at divider 3", t_r1 - t_r0, 6);
        chk(irq == 1'b0, "R10 irq low with enable clear", irq, 0);
        wr(1025, 8'h20);
        chk(irq == 1'b1, "R10 irq rises when enable set", irq, 1);
        wr(1025, 8'h10);
        chk(irq == 1'b0, "R10 irq low after clear", irq, 0);

        // R7 two fragments under one chip select
        run_cmd(5, 1'b0, 1'b0, 3);
        chk(spi_cs_n == 1'b0, "R7 cs held after non-last fragment", spi_cs_n, 0);
        check_rx(5, "R4 first fragment receive");
        chk(spi_cs_n == 1'b0, "R7 cs still held while idle", spi_cs_n, 0);
        run_cmd(2, 1'b1, 1'b0, 4);
        chk(spi_cs_n == 1'b1, "R7 cs released after last fragment", spi_cs_n, 1);
        check_rx(2, "R4 second fragment continues stream");

        // R8 release sequence
        run_cmd(2, 1'b0, 1'b0, 5);
        check_rx(2, "R4 receive before release");
        chk(spi_cs_n == 1'b0, "R8 cs low before release", spi_cs_n, 0);
        wr(1025, 8'h40);
        wr(1025, 8'h00);
        chk(spi_cs_n == 1'b1, "R8 cs high after release write", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R8 no clocking on release", spi_sck, 0);

        // R11 writes while busy
        wr(1026, 8);
        wr(300, 8'h11);
        prep(2, 6);
        launch(2, 1'b1, 1'b0);
        rd(1025, v); chk(v[7] == 1'b1, "R11 start reads 1 while busy", v, 8'h80);
        wr(300, 8'hEE);
        wr(1024, 8'h09);
        wr(1025, 8'h80);
        wait_done();
        check_rx(2, "R11 receive unaffected by busy writes");
        rd(300, v); chk(v == 8'h11, "R11 buffer write ignored while busy", v, 8'h11);
        rd(1024, v); chk(v == 8'h02, "R11 length write ignored while busy", v, 8'h02);

        // R5 full buffer with length 0, divider 1
        wr(1026, 1);
        run_cmd(1024, 1'b1, 1'b0, 7);
        check_rx(1024, "R5 full 1024-byte transfer");
        chk(t_r1 - t_r0 == 2, "R6 bit period at divider 1", t_r1 - t_r0, 2);

        // R6 divider 0 acts as 1
        wr(1026, 0);
        run_cmd(2, 1'b1, 1'b0, 8);
        check_rx(2, "R4 receive at divider 0");
        chk(t_r1 - t_r0 == 2, "R6 divider 0 acts as 1", t_r1 - t_r0, 2);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule